// File: doc/BRIEF.md
# Operand Address Sequencer

This block resolves the memory source operand of a register-memory ALU instruction. At a start pulse it takes an addressing-mode code, an access-size code, a base register value, an index register value and a 16-bit constant field. From these it forms one or two read addresses, runs them one after another over a single read port with a request/valid handshake, and returns the operand with a one-cycle done pulse. The immediate mode needs no read at all. The memory-indirect mode follows a pointer, so it makes two reads in a row. The post-increment and pre-decrement modes also give the updated base value, with a write enable, for the register file.

The constant field is sign-extended to the datapath width. The access size d is 1, 2 or 4 bytes. It is the step for the two updating modes, and the scaled mode multiplies the index by it. The unit takes a new request only while it is idle. Once a read request is raised, it stays asserted, with a steady address, until the memory answers.

Mode codes (3 bits): 0 immediate, 1 base+displacement, 2 base+index, 3 absolute, 4 memory indirect, 5 post-increment, 6 pre-decrement, 7 scaled index. Size codes (2 bits): 0 gives d=1, 1 gives d=2, 2 and 3 give d=4.

Top module: `opnd_addr_seq`

## Requirements
- R1: In mode 0 the operand is the sign-extended constant field. done_o rises one clock after the accepted start, and no memory request is made.
- R2: In mode 1 the single read address is base plus the sign-extended constant; a zero constant reads at the base itself.
- R3: Mode 2 reads once at base plus index; mode 3 reads once at the sign-extended constant.
- R4: Mode 4 reads a pointer at the base address, then reads the operand at that pointer, for exactly two reads.
- R5: Mode 5 reads at the unmodified base and gives base plus d as the writeback value.
- R6: Mode 6 computes base minus d, uses it as the read address and gives it as the writeback value.
- R7: Mode 7 reads at sign-extended constant plus base plus index shifted left by log2(d).
- R8: Size code 0 selects d=1, code 1 selects d=2, codes 2 and 3 select d=4.
- R9: wb_en_o is high only in modes 5 and 6, for exactly the cycle in which done_o is high.
- R10: A start pulse while busy_o is high is ignored; the request in progress finishes unchanged and no extra done pulse follows.
- R11: Once mem_req_o rises, it and mem_addr_o hold steady until a cycle with mem_rvalid_i high. After the final read, mem_req_o falls.
- R12: After reset, done_o, busy_o, mem_req_o and wb_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| mode_i | input | 3 | Addressing-mode code |
| size_i | input | 2 | Access-size code |
| base_i | input | DW | Base register value |
| index_i | input | DW | Index register value |
| imm_i | input | CW | Constant / displacement field |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | DW | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | DW | Resolved operand |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | DW | Base writeback value |

## Verification
The bench's memory model returns a hash of the address, so a wrong address shows up as a wrong operand. The memory answers only after several wait cycles, so a design that drops or moves its request before the answer arrives will be caught. The cases targeted are:
- A negative displacement. A design that zero-extends it reads far above the base.
- Pre-decrement against post-increment. Swapping when the register update is applied shifts the address by d.
- Size code 3. It must act like code 2, so a design that shifts by 3 is caught.
- The two-read indirect mode. A design that stops after the pointer read returns the pointer and not the operand.
- A start pulse sent mid-request. A design that accepts it corrupts the result or gives a second done.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_DISP  = 3'd1,
    AM_INDEX = 3'd2,
    AM_ABS   = 3'd3,
    AM_MIND  = 3'd4,
    AM_AINC  = 3'd5,
    AM_ADEC  = 3'd6,
    AM_SCALE = 3'd7
  } amode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PTR   = 2'd1,
    ST_FINAL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/opseq_addr_gen.sv
module opseq_addr_gen
  import opseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic [2:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] index_i,
  input  logic [CW-1:0] imm_i,
  output logic [DW-1:0] cext_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wb_o
);
  localparam int EXTW = DW - CW;

  logic [1:0]    shamt;
  logic [DW-1:0] step;
  logic [DW-1:0] scaled_idx;

  assign cext_o = {{EXTW{imm_i[CW-1]}}, imm_i};

  always_comb begin
    case (size_i)
      2'd0:    shamt = 2'd0;
      2'd1:    shamt = 2'd1;
      default: shamt = 2'd2;
    endcase
  end

  assign step       = DW'(1) << shamt;
  assign scaled_idx = index_i << shamt;

  always_comb begin
    wb_o = base_i;
    case (amode_t'(mode_i))
      AM_DISP:  addr_o = base_i + cext_o;
      AM_INDEX: addr_o = base_i + index_i;
      AM_ABS:   addr_o = cext_o;
      AM_AINC: begin
        addr_o = base_i;
        wb_o   = base_i + step;
      end
      AM_ADEC: begin
        wb_o   = base_i - step;
        addr_o = wb_o;
      end
      AM_SCALE: addr_o = cext_o + base_i + scaled_idx;
      default:  addr_o = base_i;
    endcase
  end
endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] gen_addr_i,
  input  logic [DW-1:0] gen_wb_i,
  input  logic [DW-1:0] cext_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] operand_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_data_o
);
  seq_state_t    st;
  amode_t        mode_q;
  logic [DW-1:0] wbv_q;
  logic          upd_mode;

  assign upd_mode = (mode_q == AM_AINC) || (mode_q == AM_ADEC);
  assign busy_o   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= AM_IMM;
      wbv_q      <= '0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      done_o     <= 1'b0;
      operand_o  <= '0;
      wb_en_o    <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      done_o  <= 1'b0;
      wb_en_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= amode_t'(mode_i);
            wbv_q  <= gen_wb_i;
            if (amode_t'(mode_i) == AM_IMM) begin
              operand_o <= cext_i;
              done_o    <= 1'b1;
            end else begin
              mem_req_o  <= 1'b1;
              mem_addr_o <= gen_addr_i;
              st <= (amode_t'(mode_i) == AM_MIND) ? ST_PTR : ST_FINAL;
            end
          end
        end
        ST_PTR: begin
          if (mem_rvalid_i) begin
            mem_addr_o <= mem_rdata_i;
            st         <= ST_FINAL;
          end
        end
        ST_FINAL: begin
          if (mem_rvalid_i) begin
            mem_req_o <= 1'b0;
            operand_o <= mem_rdata_i;
            done_o    <= 1'b1;
            if (upd_mode) begin
              wb_en_o   <= 1'b1;
              wb_data_o <= wbv_q;
            end
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))) // R11
    else $error("request dropped or address moved");

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> done_o) // R9
    else $error("writeback without done");

  AST_WB_MODE: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> upd_mode) // R9
    else $error("writeback in non-updating mode");

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(mode_q)) // R10
    else $error("mode changed while busy");

  AST_IMM_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && amode_t'(mode_i) == AM_IMM) |=> (!mem_req_o && done_o)) // R1
    else $error("immediate mode touched memory");

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_req_o && !busy_o)) // R11
    else $error("done while request open");
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] index_i,
  input  logic [CW-1:0] imm_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] operand_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_data_o
);
  logic [DW-1:0] cext;
  logic [DW-1:0] gen_addr;
  logic [DW-1:0] gen_wb;

  opseq_addr_gen #(.DW(DW), .CW(CW)) u_gen (
    .mode_i (mode_i),
    .size_i (size_i),
    .base_i (base_i),
    .index_i(index_i),
    .imm_i  (imm_i),
    .cext_o (cext),
    .addr_o (gen_addr),
    .wb_o   (gen_wb)
  );

  opseq_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .gen_addr_i  (gen_addr),
    .gen_wb_i    (gen_wb),
    .cext_i      (cext),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .operand_o   (operand_o),
    .wb_en_o     (wb_en_o),
    .wb_data_o   (wb_data_o)
  );
endmodule

// File: tb/opnd_addr_seq_tb_top.sv
module opnd_addr_seq_tb_top;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [2:0]    mode_i = '0;
  logic [1:0]    size_i = '0;
  logic [DW-1:0] base_i = '0;
  logic [DW-1:0] index_i = '0;
  logic [CW-1:0] imm_i = '0;
  logic          mem_req_o;
  logic [DW-1:0] mem_addr_o;
  logic          mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o, wb_en_o;
  logic [DW-1:0] operand_o, wb_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 3;
  int wait_cnt = 0;
  int reads    = 0;
  int hold_err = 0;
  int wb_err   = 0;
  logic          prev_req = 1'b0;
  logic          prev_rv  = 1'b0;
  logic [DW-1:0] prev_addr = '0;

  always #5 clk = ~clk;

  opnd_addr_seq #(.DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .size_i(size_i),
    .base_i(base_i), .index_i(index_i), .imm_i(imm_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .operand_o(operand_o),
    .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return a * 32'h0000_9E37 + 32'h1234_5678;
  endfunction

  function automatic logic [DW-1:0] sx(input logic [CW-1:0] c);
    return {{(DW-CW){c[CW-1]}}, c};
  endfunction

  // memory model with wait states
  always @(posedge clk) begin
    if (mem_req_o && !mem_rvalid_i && wait_cnt >= lat) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= memf(mem_addr_o);
      wait_cnt     <= 0;
      reads        <= reads + 1;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (mem_req_o && !mem_rvalid_i) wait_cnt <= wait_cnt + 1;
    end
  end

  // protocol monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_req && !prev_rv && (!mem_req_o || mem_addr_o != prev_addr)) hold_err++;
      if (wb_en_o && !done_o) wb_err++;
    end
    prev_req  = mem_req_o;
    prev_rv   = mem_rvalid_i;
    prev_addr = mem_addr_o;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [DW-1:0] b,
                       input logic [DW-1:0] x, input logic [CW-1:0] c);
    @(negedge clk);
    mode_i = m; size_i = s; base_i = b; index_i = x; imm_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done_o && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (!done_o) check({req, " done timeout"}, 0, 1);
  endtask

  task automatic run_op(input string req, input logic [2:0] m, input logic [1:0] s,
                        input logic [DW-1:0] b, input logic [DW-1:0] x, input logic [CW-1:0] c,
                        input logic [DW-1:0] exp_op, input int exp_reads,
                        input logic exp_wben, input logic [DW-1:0] exp_wbd);
    reads = 0;
    issue(m, s, b, x, c);
    wait_done(req);
    check({req, " operand"}, operand_o, exp_op);
    check({req, " wb_en"}, DW'(wb_en_o), DW'(exp_wben));
    if (exp_wben) check({req, " wb_data"}, wb_data_o, exp_wbd);
    check({req, " read count"}, DW'(reads), DW'(exp_reads));
    @(negedge clk);
    check({req, " done one cycle"}, DW'(done_o), 0);
  endtask

  task automatic t_reset;
    check("R12 done", DW'(done_o), 0);
    check("R12 busy", DW'(busy_o), 0);
    check("R12 req", DW'(mem_req_o), 0);
    check("R12 wb_en", DW'(wb_en_o), 0);
  endtask

  task automatic t_imm;
    reads = 0;
    issue(3'd0, 2'd0, 32'h55, 32'h0, 16'hFF80);
    check("R1 done next cycle", DW'(done_o), 1);
    check("R1 operand", operand_o, 32'hFFFF_FF80);
    check("R1 no request", DW'(mem_req_o) + DW'(reads), 0);
    check("R9 imm wb_en", DW'(wb_en_o), 0);
  endtask

  task automatic t_busy_ignore;
    reads = 0;
    lat = 4;
    issue(3'd4, 2'd0, 32'h40, 32'h0, 16'h0);
    @(negedge clk);
    mode_i = 3'd0; imm_i = 16'h0007; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R10");
    check("R10 operand unchanged", operand_o, memf(memf(32'h40)));
    check("R10 read count", DW'(reads), 2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done_o || mem_req_o) check("R10 no extra done/request", 1, 0);
    end
    check("R10 idle after", DW'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_imm();
    run_op("R2 negative disp", 3'd1, 2'd0, 32'h1000, 0, 16'hFFFC, memf(32'h0FFC), 1, 0, 0);
    run_op("R2 zero disp", 3'd1, 2'd0, 32'h1000, 0, 16'h0000, memf(32'h1000), 1, 0, 0);
    run_op("R3 base+index", 3'd2, 2'd0, 32'h200, 32'h34, 16'h0, memf(32'h234), 1, 0, 0);
    lat = 0;
    run_op("R3 absolute", 3'd3, 2'd0, 32'h777, 0, 16'h8000, memf(32'hFFFF_8000), 1, 0, 0);
    lat = 5;
    run_op("R4 indirect", 3'd4, 2'd0, 32'h40, 0, 16'h0, memf(memf(32'h40)), 2, 0, 0);
    run_op("R5 R8 post-inc d4", 3'd5, 2'd2, 32'h100, 0, 16'h0, memf(32'h100), 1, 1, 32'h104);
    run_op("R5 R8 post-inc d2", 3'd5, 2'd1, 32'h100, 0, 16'h0, memf(32'h100), 1, 1, 32'h102);
    lat = 2;
    run_op("R6 R8 pre-dec d1", 3'd6, 2'd0, 32'h100, 0, 16'h0, memf(32'h0FF), 1, 1, 32'h0FF);
    run_op("R6 pre-dec d4", 3'd6, 2'd2, 32'h100, 0, 16'h0, memf(32'h0FC), 1, 1, 32'h0FC);
    run_op("R7 scaled d4", 3'd7, 2'd2, 32'h1000, 32'h3, 16'h0008, memf(32'h1014), 1, 0, 0);
    run_op("R7 R8 scaled code3", 3'd7, 2'd3, 32'h1000, 32'h3, 16'hFFF8, memf(32'h1004), 1, 0, 0);
    run_op("R7 scaled d1", 3'd7, 2'd0, 32'h1000, 32'h3, 16'h0001, memf(32'h1004), 1, 0, 0);
    t_busy_ignore();
    check("R11 request hold violations", DW'(hold_err), 0);
    check("R9 wb_en outside done", DW'(wb_err), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule